// File: doc/BRIEF.md
# Locked Command Mailbox with Payload Checksum

This block is a word-addressed register mailbox. A host uses it to pass a command code and a payload to an internal responder. Before touching anything, the host claims the mailbox with a read-to-acquire lock. It then loads the command, the payload length in bytes and the payload words, and finally triggers execution. A small state machine accepts these steps in one fixed order. Any step taken out of turn parks the mailbox in an error state, which stays until the owner lets go of the lock.

Every payload opens with a checksum word. When execution is triggered, the mailbox adds up the command bytes, the payload bytes after the checksum word, and the checksum word itself. A correct checksum makes this total zero. If the total is not zero, the mailbox reports failure and never wakes the responder. If it is zero, the responder sees a busy flag and the command, and answers with done or fail. Before answering it may push result words, which the host then reads back through the data-out register. The host polls status and ends the session by writing 0 to execute.

Top module: `mbox_top`

## Requirements
- R1: After reset the status word reads 0: state idle (0), result busy (0), lock-held flag (bit 9) clear. The responder busy output is low.
- R2: Reading word index 0 while the mailbox is free returns 0, claims the lock, stores `host_id` in the owner register (index 1) and moves the state to ready-for-command (1). Reading index 0 while the lock is held returns a nonzero value. Read data appears on `host_rdata` one cycle after the read strobe.
- R3: Status word layout: result code in bits [3:0] (busy 0, data ready 1, complete 2, failure 3), state in bits [8:6] (idle 0, ready-for-command 1, ready-for-length 2, ready-for-data 3, responder running 4, host side 5, error 6), lock held in bit 9, all other bits 0. Writing the command (index 2) in state 1 moves to state 2. Writing the byte length (index 3) in state 2 moves to state 3.
- R4: A declared length above 4*DEPTH bytes (256 by default) moves the state to error (6). A length of exactly 256 is accepted.
- R5: While the state is 1, 2 or 3, a write to the command, length, data-in (index 4) or execute (index 6, value 1) register that does not match the expected step moves the state to error. This includes execute before all declared payload words have arrived.
- R6: In state 3, a data-in write beyond ceil(length/4) words moves the state to error.
- R7: The checksum is word 0 of the payload. On execute, the 32-bit sum of the four command bytes, the bytes of words 1 and up that lie within the declared length (byte j of a word is bits [8j+7:8j]), and the whole checksum word is formed. If that sum is zero, the state goes to 4, the result stays busy and `rsp_busy` rises with `rsp_cmd` equal to the command.
- R8: If that sum is nonzero, the state goes to 5 with result failure (3), and `rsp_busy` stays low.
- R9: While in state 4, a `rsp_done` pulse moves the state to 5. The result becomes failure if `rsp_fail` is set. Otherwise it becomes data ready if any `rsp_dout_wr` word was pushed, and complete if none was.
- R10: In state 5, successive reads of data-out (index 5) return the pushed responder words in push order.
- R11: Writing 0 to execute (outside state 4), or any value to unlock (index 8), releases the lock: the state returns to idle with result busy. Error is left only this way. Writes while the lock is free are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rd | input | 1 | Register read strobe |
| host_wr | input | 1 | Register write strobe |
| host_waddr | input | AW (4) | Register word index |
| host_wdata | input | 32 | Write data |
| host_id | input | ID_W (8) | Requester identity recorded on lock grant |
| host_rdata | output | 32 | Registered read data |
| host_rvalid | output | 1 | Read data valid, one cycle after the strobe |
| rsp_busy | output | 1 | Command accepted and awaiting the responder |
| rsp_cmd | output | 32 | Command code for the responder |
| rsp_len | output | 32 | Declared payload length in bytes |
| rsp_done | input | 1 | Responder finished |
| rsp_fail | input | 1 | Responder result is failure (with done) |
| rsp_dout_wr | input | 1 | Push one result word |
| rsp_dout | input | 32 | Result word |

## Verification
The assertions check, on every cycle, several invariants of the mailbox. The lock flag agrees with the idle state. A lock read answers 0 only when it grants the lock, and a nonzero value otherwise. Error never ends without a host write. The result stays busy while the responder runs. The word counter never passes the buffer depth.

Other behaviour can only be shown by the bench's sessions, because it depends on what the host and responder do. This covers the arithmetic of the checksum over random lengths and partial last words, the choice between done, data-ready and failure, the order of the read-back words, and each out-of-order case.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CMD  = 3'd1,
    ST_LEN  = 3'd2,
    ST_DATA = 3'd3,
    ST_RUN  = 3'd4,
    ST_HOST = 3'd5,
    ST_ERR  = 3'd6
  } mb_state_e;

  localparam logic [3:0] RES_BUSY = 4'd0;
  localparam logic [3:0] RES_DATA = 4'd1;
  localparam logic [3:0] RES_DONE = 4'd2;
  localparam logic [3:0] RES_FAIL = 4'd3;

  localparam int RG_LOCK   = 0;
  localparam int RG_USER   = 1;
  localparam int RG_CMD    = 2;
  localparam int RG_DLEN   = 3;
  localparam int RG_DIN    = 4;
  localparam int RG_DOUT   = 5;
  localparam int RG_EXEC   = 6;
  localparam int RG_STATUS = 7;
  localparam int RG_UNLOCK = 8;
endpackage

// File: rtl/mbox_byte_sum.sv
module mbox_byte_sum #(
  parameter int NB = 4,
  localparam int NVW = $clog2(NB + 1)
) (
  input  logic [8*NB-1:0] word,
  input  logic [NVW-1:0]  nvalid,
  output logic [31:0]     sum
);
  logic [31:0] part [NB];

  for (genvar j = 0; j < NB; j++) begin : g_byte
    assign part[j] = (NVW'(j) < nvalid) ? {24'd0, word[8*j +: 8]} : 32'd0;
  end

  always_comb begin
    sum = 32'd0;
    for (int j = 0; j < NB; j++) sum = sum + part[j];
  end
endmodule

// File: rtl/mbox_buf.sv
module mbox_buf #(
  parameter int DEPTH = 64,
  parameter int W = 32,
  localparam int AWI = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [AWI-1:0] waddr,
  input  logic [W-1:0]   wdata,
  input  logic [AWI-1:0] raddr,
  output logic [W-1:0]   rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/mbox_top.sv
module mbox_top
  import mbox_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW = 4,
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_rd,
  input  logic            host_wr,
  input  logic [AW-1:0]   host_waddr,
  input  logic [31:0]     host_wdata,
  input  logic [ID_W-1:0] host_id,
  output logic [31:0]     host_rdata,
  output logic            host_rvalid,
  output logic            rsp_busy,
  output logic [31:0]     rsp_cmd,
  output logic [31:0]     rsp_len,
  input  logic            rsp_done,
  input  logic            rsp_fail,
  input  logic            rsp_dout_wr,
  input  logic [31:0]     rsp_dout
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = IDX_W + 1;
  localparam int MAX_BYTES = DEPTH * 4;

  mb_state_e         state_q;
  logic [3:0]        res_q;
  logic              locked_q;
  logic [ID_W-1:0]   user_q;
  logic [31:0]       cmd_q, dlen_q, acc_q;
  logic [CNT_W-1:0]  wcnt_q, outw_q;
  logic [IDX_W-1:0]  rptr_q;

  logic [31:0] exp_w, rem, bsum, mem_rd;
  logic [2:0]  nv;
  logic        din_ok, dout_ok, mem_we, release_req;
  logic [IDX_W-1:0] mem_wa;
  logic [31:0] mem_wd;

  // payload words implied by the declared byte length
  assign exp_w = (dlen_q + 32'd3) >> 2;
  assign rem   = dlen_q - {{(30-CNT_W){1'b0}}, wcnt_q, 2'b00};
  assign nv    = (state_q == ST_CMD) ? 3'd4 : ((rem >= 32'd4) ? 3'd4 : rem[2:0]);

  mbox_byte_sum #(.NB(4)) u_sum (.word(host_wdata), .nvalid(nv), .sum(bsum));

  assign din_ok  = host_wr && locked_q && state_q == ST_DATA &&
                   host_waddr == AW'(RG_DIN) && 32'(wcnt_q) < exp_w;
  assign dout_ok = state_q == ST_RUN && rsp_dout_wr && outw_q < CNT_W'(DEPTH);
  assign mem_we  = din_ok || dout_ok;
  assign mem_wa  = dout_ok ? outw_q[IDX_W-1:0] : wcnt_q[IDX_W-1:0];
  assign mem_wd  = dout_ok ? rsp_dout : host_wdata;

  mbox_buf #(.DEPTH(DEPTH), .W(32)) u_buf (
    .clk(clk), .we(mem_we), .waddr(mem_wa), .wdata(mem_wd),
    .raddr(rptr_q), .rdata(mem_rd)
  );

  assign release_req = host_wr && locked_q &&
                       (host_waddr == AW'(RG_UNLOCK) ||
                        (host_waddr == AW'(RG_EXEC) && !host_wdata[0] && state_q != ST_RUN));

  assign rsp_busy = (state_q == ST_RUN);
  assign rsp_cmd  = cmd_q;
  assign rsp_len  = dlen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE; res_q <= RES_BUSY; locked_q <= 1'b0; user_q <= '0;
      cmd_q <= '0; dlen_q <= '0; acc_q <= '0; wcnt_q <= '0; outw_q <= '0;
      rptr_q <= '0; host_rdata <= '0; host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= host_rd;
      if (host_rd) begin
        case (32'(host_waddr))
          RG_LOCK: begin
            if (!locked_q) begin
              host_rdata <= 32'd0;
              locked_q   <= 1'b1;
              user_q     <= host_id;
              state_q    <= ST_CMD;
              res_q      <= RES_BUSY;
            end else host_rdata <= 32'd1;
          end
          RG_USER:   host_rdata <= 32'(user_q);
          RG_CMD:    host_rdata <= cmd_q;
          RG_DLEN:   host_rdata <= dlen_q;
          RG_DOUT: begin
            if (state_q == ST_HOST) begin
              host_rdata <= mem_rd;
              rptr_q     <= rptr_q + 1'b1;
            end else host_rdata <= 32'd0;
          end
          RG_STATUS: host_rdata <= {22'd0, locked_q, state_q, 2'b00, res_q};
          default:   host_rdata <= 32'd0;
        endcase
      end
      // responder side
      if (state_q == ST_RUN) begin
        if (dout_ok) outw_q <= outw_q + 1'b1;
        if (rsp_done) begin
          state_q <= ST_HOST;
          rptr_q  <= '0;
          if (rsp_fail) res_q <= RES_FAIL;
          else if (outw_q != '0 || dout_ok) res_q <= RES_DATA;
          else res_q <= RES_DONE;
        end
      end
      // host writes, release has priority
      if (release_req) begin
        state_q <= ST_IDLE; locked_q <= 1'b0; res_q <= RES_BUSY;
        user_q <= '0; wcnt_q <= '0;
      end else if (host_wr && locked_q) begin
        case (state_q)
          ST_CMD: begin
            if (host_waddr == AW'(RG_CMD)) begin
              cmd_q <= host_wdata; acc_q <= bsum; state_q <= ST_LEN;
            end else if (host_waddr == AW'(RG_DLEN) || host_waddr == AW'(RG_DIN) ||
                         host_waddr == AW'(RG_EXEC)) state_q <= ST_ERR;
          end
          ST_LEN: begin
            if (host_waddr == AW'(RG_DLEN)) begin
              dlen_q  <= host_wdata;
              wcnt_q  <= '0;
              state_q <= (host_wdata > 32'(MAX_BYTES)) ? ST_ERR : ST_DATA;
            end else if (host_waddr == AW'(RG_CMD) || host_waddr == AW'(RG_DIN) ||
                         host_waddr == AW'(RG_EXEC)) state_q <= ST_ERR;
          end
          ST_DATA: begin
            if (host_waddr == AW'(RG_DIN)) begin
              if (din_ok) begin
                acc_q  <= acc_q + ((wcnt_q == '0) ? host_wdata : bsum);
                wcnt_q <= wcnt_q + 1'b1;
              end else state_q <= ST_ERR;
            end else if (host_waddr == AW'(RG_EXEC)) begin
              if (32'(wcnt_q) != exp_w) state_q <= ST_ERR;
              else if (acc_q == 32'd0) begin
                state_q <= ST_RUN; outw_q <= '0;
              end else begin
                state_q <= ST_HOST; res_q <= RES_FAIL; rptr_q <= '0;
              end
            end else if (host_waddr == AW'(RG_CMD) || host_waddr == AW'(RG_DLEN))
              state_q <= ST_ERR;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mbox_chk.sv
module mbox_chk #(
  parameter int DEPTH = 64,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          host_rd,
  input logic          host_wr,
  input logic [AW-1:0] host_waddr,
  input logic [31:0]   host_rdata,
  input logic          host_rvalid,
  input logic [2:0]    state,
  input logic          locked,
  input logic [3:0]    res,
  input logic [$clog2(DEPTH):0] wcnt
);
  a_r3_state_legal: assert property (@(posedge clk) disable iff (rst) state <= 3'd6);

  a_r11_lock_tracks_idle: assert property (@(posedge clk) disable iff (rst)
    locked == (state != 3'd0));

  a_r2_grant_reads_zero: assert property (@(posedge clk) disable iff (rst)
    host_rd && host_waddr == '0 && !locked |=> host_rvalid && host_rdata == 32'd0 && locked);

  a_r2_held_reads_nonzero: assert property (@(posedge clk) disable iff (rst)
    host_rd && host_waddr == '0 && locked |=> host_rdata != 32'd0);

  a_r7_run_result_busy: assert property (@(posedge clk) disable iff (rst)
    state == 3'd4 |-> res == 4'd0);

  a_r11_error_sticky: assert property (@(posedge clk) disable iff (rst)
    state == 3'd6 && !host_wr |=> state == 3'd6);

  a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
    32'(wcnt) <= DEPTH);
endmodule

bind mbox_top mbox_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .host_rd(host_rd), .host_wr(host_wr), .host_waddr(host_waddr),
  .host_rdata(host_rdata), .host_rvalid(host_rvalid), .state(state_q),
  .locked(locked_q), .res(res_q), .wcnt(wcnt_q)
);

// File: tb/sim_mbox_top.sv
`timescale 1ns/1ps
module sim_mbox_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_rd = 0, host_wr = 0;
  logic [3:0] host_waddr = 0;
  logic [31:0] host_wdata = 0;
  logic [7:0] host_id = 8'h5A;
  logic [31:0] host_rdata;
  logic host_rvalid, rsp_busy;
  logic [31:0] rsp_cmd, rsp_len;
  logic rsp_done = 0, rsp_fail = 0, rsp_dout_wr = 0;
  logic [31:0] rsp_dout = 0;

  int nchk = 0, nfail = 0;
  logic [31:0] pl [64];
  logic [31:0] dq [64];

  always #2.5 clk = ~clk;

  mbox_top u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); host_wr = 1; host_waddr = 4'(a); host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk); host_rd = 1; host_waddr = 4'(a);
    @(negedge clk); host_rd = 0; v = host_rdata;
  endtask

  function automatic logic [31:0] stw(input int st, input int res, input bit lk);
    return {22'd0, lk, 3'(st), 2'b00, 4'(res)};
  endfunction

  function automatic logic [31:0] bytes(input logic [31:0] w, input int n);
    logic [31:0] s = 0;
    for (int j = 0; j < 4; j++) if (j < n) s += {24'd0, w[8*j +: 8]};
    return s;
  endfunction

  task automatic fill(input logic [31:0] cmd, input int nb, input bit bad);
    logic [31:0] s;
    int nw = (nb + 3) / 4;
    s = 32'd0 - bytes(cmd, 4);
    for (int k = 1; k < nw; k++) begin
      pl[k] = $urandom;
      s -= bytes(pl[k], nb - 4 * k);
    end
    pl[0] = bad ? s + 32'd1 : s;
  endtask

  // mode 0: done, 1: fail, 2: result words
  task automatic session(input logic [31:0] cmd, input int nb, input bit bad,
                         input int mode, input int nd);
    logic [31:0] v;
    int nw = (nb + 3) / 4;
    fill(cmd, nb, bad);
    rd(0, v); chk("R2 grant", v, 0);
    rd(7, v); chk("R2 ready-for-command", v, stw(1, 0, 1));
    wr(2, cmd);
    rd(7, v); chk("R3 after command", v, stw(2, 0, 1));
    wr(3, 32'(nb));
    rd(7, v); chk("R3 after length", v, stw(3, 0, 1));
    for (int k = 0; k < nw; k++) wr(4, pl[k]);
    wr(6, 1);
    rd(7, v);
    if (bad) begin
      chk("R8 checksum failure", v, stw(5, 3, 1));
      chk("R8 responder idle", 32'(rsp_busy), 0);
    end else begin
      chk("R7 running", v, stw(4, 0, 1));
      chk("R7 busy", 32'(rsp_busy), 1);
      chk("R7 command", rsp_cmd, cmd);
      for (int i = 0; i < nd; i++) begin
        dq[i] = $urandom;
        @(negedge clk); rsp_dout_wr = 1; rsp_dout = dq[i];
      end
      @(negedge clk); rsp_dout_wr = 0; rsp_done = 1; rsp_fail = (mode == 1);
      @(negedge clk); rsp_done = 0; rsp_fail = 0;
      rd(7, v);
      chk("R9 result", v, stw(5, mode == 1 ? 3 : (nd > 0 ? 1 : 2), 1));
      for (int i = 0; i < nd; i++) begin
        rd(5, v); chk("R10 data-out order", v, dq[i]);
      end
    end
    wr(6, 0);
    rd(7, v); chk("R11 released", v, 0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    int unsigned seed_set;
    seed_set = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(7, v); chk("R1 reset status", v, 0);
    chk("R1 rsp_busy low", 32'(rsp_busy), 0);
    // R11 writes while free are ignored
    wr(2, 32'h1234); wr(6, 1);
    rd(7, v); chk("R11 ignored while free", v, 0);
    // R2 second lock read, owner
    rd(0, v); chk("R2 grant", v, 0);
    rd(0, v); chk("R2 held reads nonzero", 32'(v != 0), 1);
    rd(1, v); chk("R2 owner id", v, 32'h5A);
    wr(8, 32'h0);
    rd(7, v); chk("R11 unlock register", v, 0);
    // directed example command, 196 bytes
    session(32'h53494756, 196, 0, 0, 0);
    session(32'h53494756, 196, 1, 0, 0);
    // R4 boundaries
    rd(0, v); wr(2, 32'h1); wr(3, 257);
    rd(7, v); chk("R4 length too large", v, stw(6, 0, 1));
    wr(4, 32'h0);
    rd(7, v); chk("R11 error sticky", v, stw(6, 0, 1));
    wr(6, 0);
    rd(7, v); chk("R11 error cleared by release", v, 0);
    rd(0, v); wr(2, 32'h1); wr(3, 256);
    rd(7, v); chk("R4 length 256 accepted", v, stw(3, 0, 1));
    wr(8, 0);
    // R5 out of order
    rd(0, v); wr(4, 32'h9);
    rd(7, v); chk("R5 data before command", v, stw(6, 0, 1));
    wr(8, 0);
    rd(0, v); wr(2, 32'h2); wr(6, 1);
    rd(7, v); chk("R5 execute before length", v, stw(6, 0, 1));
    wr(8, 0);
    rd(0, v); wr(2, 32'h2); wr(3, 12); wr(4, 0); wr(6, 1);
    rd(7, v); chk("R5 execute with short payload", v, stw(6, 0, 1));
    wr(8, 0);
    // R6 extra word: 5 bytes -> 2 words
    rd(0, v); wr(2, 32'h3); wr(3, 5); wr(4, 0); wr(4, 0);
    rd(7, v); chk("R6 two words ok", v, stw(3, 0, 1));
    wr(4, 0);
    rd(7, v); chk("R6 third word error", v, stw(6, 0, 1));
    wr(8, 0);
    // random sessions
    for (int n = 0; n < 60; n++) begin
      int nb = 1 + int'($urandom % 256);
      bit bad = ($urandom % 4) == 0;
      int mode = int'($urandom % 3);
      int nd = (mode == 2) ? 1 + int'($urandom % 64) : 0;
      session($urandom, nb, bad, mode, nd);
    end
    summary();
    $finish;
  end
endmodule